// File: doc/BRIEF.md
# Two-wire serial target receive front end

This block is the bit-level receive side of a two-wire serial target. A system clock oversamples the clock line (SCL) and the data line (SDA) through a synchronizer. From the synchronized samples the block finds start and stop conditions. It shifts in 8-bit words, most significant bit first, and acknowledges each word by enabling the open-drain pull-down on SDA for the whole ninth bus clock.

Each received word appears on a data output together with a one-cycle valid strobe. Start and stop conditions are reported as one-cycle pulses. A standby flag is high out of reset. It drops when a start is seen. After a stop it returns only once the internal-busy input from the surrounding target logic is low.

The block ignores all bus traffic until a start has been seen, and it never acknowledges before then. Address matching, memory access, transmit and clock stretching belong to other blocks.

Top module: `twi_target_rx`

## Requirements
- R1: Out of reset, standby_o is 1, sda_pd_o is 0, byte_o is 0, and byte_vld_o, start_o and stop_o are 0.
- R2: A falling SDA while SCL stays high (after synchronization) produces a one-cycle start_o pulse and opens a new word with the bit count at zero.
- R3: A rising SDA while SCL stays high produces a one-cycle stop_o pulse and ends reception.
- R4: While receiving, SDA is sampled on each synchronized SCL rising edge. Bits enter most significant first. After the 8th bit, byte_o holds the word and byte_vld_o is high for exactly one cycle.
- R5: sda_pd_o rises on the SCL falling edge that follows the 8th bit and falls on the SCL falling edge that ends the 9th clock. SCL rises during this acknowledge clock are not taken as data.
- R6: Before any start, and after a stop, SCL clocking produces no byte_vld_o and no sda_pd_o.
- R7: A start in the middle of a word discards the partial word, so the next 8 bits form a fresh word.
- R8: start_o clears standby_o in the same cycle that start_o is high.
- R9: After a stop, standby_o rises one cycle after the first cycle in which busy_i is 0, and never while busy_i was 1 in the cycle before.
- R10: SDA changes while SCL is low produce neither start_o nor stop_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| busy_i | input | 1 | Internal operation in progress |
| sda_pd_o | output | 1 | Enable for the open-drain pull-down on SDA |
| byte_o | output | 8 | Last received word |
| byte_vld_o | output | 1 | One-cycle strobe for a new word |
| start_o | output | 1 | One-cycle start-condition pulse |
| stop_o | output | 1 | One-cycle stop-condition pulse |
| standby_o | output | 1 | Standby status |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and 8-bit words. With these, the whole acknowledge window and the sync latency of three cycles fit inside an 8-cycle half bus period. The bench wires SDA as open drain, so the block's own pull-down is what the master sees during the ninth clock. This lets a repeated start in the middle of a word, a stop held off by busy_i, and SDA toggling under a low SCL all be compared cycle by cycle against a behavioural model.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;
  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } twi_ev_t;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '1;  // idle bus is high
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i > 0) ? i-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det
  import twi_rx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_s_i,
  input  logic    sda_s_i,
  output twi_ev_t ev_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s_i;
      sda_p_q <= sda_s_i;
    end
  end

  always_comb begin
    ev_o.scl_rise = scl_s_i & ~scl_p_q;
    ev_o.scl_fall = ~scl_s_i & scl_p_q;
    ev_o.start    = scl_s_i & scl_p_q & sda_p_q & ~sda_s_i;
    ev_o.stop     = scl_s_i & scl_p_q & ~sda_p_q & sda_s_i;
    ev_o.sda      = sda_s_i;
  end

  // R10: a condition needs SCL high in two consecutive samples
  a_r10_cond_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o.start || ev_o.stop) |-> ($past(scl_s_i) && scl_s_i));
endmodule

// File: rtl/twi_shifter.sv
module twi_shifter
  import twi_rx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  twi_ev_t           ev_i,
  output logic              sda_pd_o,
  output logic [WORD_W-1:0] byte_o,
  output logic              byte_vld_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              active_q, ack_pend_q, in_ack_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q, sh_nxt;

  assign sh_nxt = {sh_q[WORD_W-2:0], ev_i.sda};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      ack_pend_q <= 1'b0;
      in_ack_q   <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      sda_pd_o   <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (ev_i.start) begin
        active_q   <= 1'b1;
        cnt_q      <= '0;
        sh_q       <= '0;
        ack_pend_q <= 1'b0;
        in_ack_q   <= 1'b0;
        sda_pd_o   <= 1'b0;
      end else if (ev_i.stop) begin
        active_q   <= 1'b0;
        cnt_q      <= '0;
        ack_pend_q <= 1'b0;
        in_ack_q   <= 1'b0;
        sda_pd_o   <= 1'b0;
      end else if (active_q) begin
        if (ev_i.scl_rise && !ack_pend_q && !in_ack_q) begin
          sh_q <= sh_nxt;
          if (cnt_q == LAST) begin
            byte_o     <= sh_nxt;
            byte_vld_o <= 1'b1;
            ack_pend_q <= 1'b1;
            cnt_q      <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        if (ev_i.scl_fall && ack_pend_q) begin
          sda_pd_o   <= 1'b1;
          ack_pend_q <= 1'b0;
          in_ack_q   <= 1'b1;
        end else if (ev_i.scl_fall && in_ack_q) begin
          sda_pd_o <= 1'b0;
          in_ack_q <= 1'b0;
        end
      end
    end
  end

  a_r4_vld_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
  a_r6_vld_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(active_q));
  a_r5_pd_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pd_o |-> active_q);
  a_r5_pd_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> $past(ev_i.scl_fall));
endmodule

// File: rtl/twi_standby.sv
module twi_standby (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic busy_i,
  output logic standby_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      standby_o <= 1'b1;
      pend_q    <= 1'b0;
    end else if (start_i) begin
      standby_o <= 1'b0;
      pend_q    <= 1'b0;
    end else if (stop_i) begin
      pend_q <= 1'b1;
    end else if (pend_q && !busy_i) begin
      standby_o <= 1'b1;
      pend_q    <= 1'b0;
    end
  end

  a_r9_no_standby_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> !$past(busy_i));
endmodule

// File: rtl/twi_target_rx.sv
module twi_target_rx
  import twi_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  output logic              sda_pd_o,
  output logic [WORD_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              standby_o
);
  logic [1:0] line_s;
  twi_ev_t    ev;

  twi_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(line_s)
  );

  twi_cond_det u_det (
    .clk_i, .rst_ni, .scl_s_i(line_s[1]), .sda_s_i(line_s[0]), .ev_o(ev)
  );

  twi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .ev_i(ev), .sda_pd_o, .byte_o, .byte_vld_o
  );

  twi_standby u_sb (
    .clk_i, .rst_ni, .start_i(ev.start), .stop_i(ev.stop), .busy_i, .standby_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= ev.start;
      stop_o  <= ev.stop;
    end
  end

  a_r2_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  a_r8_start_clears_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !standby_o);
  a_r3_stop_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
endmodule

// File: tb/sim_twi_target_rx.sv
`timescale 1ns/1ps
module sim_twi_target_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic pd, bvld, sto, spo, sb;
  logic [7:0] bdat;
  wire sda_line = sda_m & ~pd;

  always #10 clk = ~clk;

  twi_target_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .busy_i(busy),
    .sda_pd_o(pd), .byte_o(bdat), .byte_vld_o(bvld), .start_o(sto),
    .stop_o(spo), .standby_o(sb)
  );

  int vec = 0, bad = 0;
  int nbytes = 0, nstart = 0, nstop = 0;
  byte unsigned got[$];

  // behavioural reference model
  bit q1 [2], s [2], p [2];  // [1]=scl [0]=sda
  bit m_act, m_pend, m_inack, m_pd, m_vld, m_sto, m_spo, m_sb, m_sbp;
  int m_cnt;
  byte unsigned m_sh, m_dat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 = '{1, 1}; s = '{1, 1}; p = '{1, 1};
      m_act = 0; m_pend = 0; m_inack = 0; m_pd = 0; m_vld = 0;
      m_sto = 0; m_spo = 0; m_sb = 1; m_sbp = 0; m_cnt = 0; m_sh = 0; m_dat = 0;
    end else begin
      bit rise, fall, st, sp;
      rise = s[1] && !p[1];
      fall = !s[1] && p[1];
      st = s[1] && p[1] && p[0] && !s[0];
      sp = s[1] && p[1] && !p[0] && s[0];
      m_vld = 0; m_sto = st; m_spo = sp;
      if (st) begin
        m_act = 1; m_cnt = 0; m_sh = 0; m_pend = 0; m_inack = 0; m_pd = 0;
        m_sb = 0; m_sbp = 0;
      end else begin
        if (sp) begin
          m_act = 0; m_cnt = 0; m_pend = 0; m_inack = 0; m_pd = 0;
        end else if (m_act) begin
          if (rise && !m_pend && !m_inack) begin
            m_sh = byte'({m_sh, s[0]});
            m_cnt++;
            if (m_cnt == 8) begin m_cnt = 0; m_vld = 1; m_dat = m_sh; m_pend = 1; end
          end
          if (fall && m_pend) begin m_pd = 1; m_pend = 0; m_inack = 1; end
          else if (fall && m_inack) begin m_pd = 0; m_inack = 0; end
        end
        if (sp) m_sbp = 1;
        else if (m_sbp && !busy) begin m_sb = 1; m_sbp = 0; end
      end
      p = s; s = q1; q1 = '{sda_line, scl};
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R5 sda_pd_o", pd, m_pd);
    chk("R4 byte_vld_o", bvld, m_vld);
    chk("R4 byte_o", bdat, m_dat);
    chk("R2 start_o", sto, m_sto);
    chk("R3 stop_o", spo, m_spo);
    chk("R9 standby_o", sb, m_sb);
    if (bvld) begin nbytes++; got.push_back(bdat); end
    if (sto) nstart++;
    if (spo) nstop++;
  end

  localparam int HP = 8;
  task automatic w(int n); repeat (n) @(negedge clk); endtask
  task automatic send_bit(bit b);
    scl = 0; w(2); sda_m = b; w(HP); scl = 1; w(HP);
  endtask
  task automatic do_start();
    scl = 0; w(2); sda_m = 1; w(HP); scl = 1; w(HP); sda_m = 0; w(HP);
  endtask
  task automatic do_stop();
    scl = 0; w(2); sda_m = 0; w(HP); scl = 1; w(HP); sda_m = 1; w(HP);
  endtask
  task automatic send_byte(byte unsigned v, bit expect_ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    scl = 0; w(2); sda_m = 1; w(HP); scl = 1; w(HP / 2);
    chk(expect_ack ? "R5 ack low in 9th clock" : "R6 no ack", sda_line, expect_ack ? 0 : 1);
    w(HP / 2);
  endtask

  int cyc = 0;
  bit timeout = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !timeout) begin
      timeout = 1; bad++; vec++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    w(3);
    chk("R1 standby", sb, 1); chk("R1 pd", pd, 0); chk("R1 byte", bdat, 0);
    chk("R1 pulses", {bvld, sto, spo}, 0);
    rst_n = 1; w(4);
    // R6: clocking with no start
    send_byte(8'hA5, 0); scl = 0; w(HP);
    chk("R6 no byte before start", nbytes, 0);
    // R2 R4 R5 R8
    do_start();
    chk("R2 one start", nstart, 1);
    chk("R8 standby cleared", sb, 0);
    send_byte(8'h3C, 1);
    send_byte(8'hFF, 1);
    send_byte(8'h00, 1);
    // R3 R9 stop while busy
    busy = 1;
    do_stop();
    chk("R3 one stop", nstop, 1);
    w(40);
    chk("R9 held while busy", sb, 0);
    busy = 0; w(3);
    chk("R9 standby after busy clears", sb, 1);
    // R6 after stop
    send_byte(8'h55, 0); scl = 0; w(HP);
    chk("R6 no byte after stop", nbytes, 3);
    // R10: SDA toggles with SCL low
    for (int i = 0; i < 6; i++) begin sda_m = ~sda_m; w(HP); end
    sda_m = 1; w(HP);
    chk("R10 no start", nstart, 1); chk("R10 no stop", nstop, 1);
    // R7: repeated start mid word
    do_start();
    send_bit(1); send_bit(0); send_bit(1);
    do_start();
    send_byte(8'h81, 1);
    do_stop(); w(10);
    chk("R7 byte count", nbytes, 4);
    chk("R4 byte0", got[0], 8'h3C); chk("R4 byte1", got[1], 8'hFF);
    chk("R4 byte2", got[2], 8'h00); chk("R7 fresh word", got[3], 8'h81);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule